// File: doc/BRIEF.md
# Floating-Point Issue Gate with Reservation Table

This block decides, one cycle at a time, whether the next floating-point operation may enter a unit whose internal stages are shared between operation types. The unit has eight stage resources: unpack, shift, add, round, divide, exception test, first multiply and second multiply. Each operation type claims a fixed set of resources in each cycle after it starts. The block keeps a window of future cycles, each with an eight-bit record of the resources already claimed. A request is tested against that window. If the request overlaps nothing, the block issues it and merges its claims into the window. If it overlaps, the block stalls it, and the requester presents it again on a later cycle.

The window moves forward by one cycle on every clock. Its first entry is presented as the set of stage resources in use in the current cycle. The arithmetic and the register dependences between operations are handled elsewhere.

Top module: `fp_issue_gate`

## Requirements
- R1: Resource bits are unpack=bit0, shift=bit1, add=bit2, round=bit3, divide=bit4, exception=bit5, multiply-first=bit6, multiply-second=bit7. `stage_busy_o` shows the resources claimed for the current cycle. In the cycle after an issue it includes the new operation's first step (unpack, 8'h01), and later steps follow one per cycle.
- R2: A request issues only when, for every future step k of its pattern, the bitwise AND of that step with the window entry for the same cycle is zero. Any overlap stalls it.
- R3: Operation code 0 (add/subtract) claims unpack, then shift+add, then add+round, then round+shift (8'h01, 8'h06, 8'h0C, 8'h0A). When add requests are held continuously, an add issues every third cycle.
- R4: Code 1 (multiply) claims unpack, exception+first-multiply, first-multiply three times, second-multiply, second-multiply+add, then round (8'h01, 8'h60, 8'h40, 8'h40, 8'h40, 8'h80, 8'h84, 8'h08). Held multiply requests issue every fourth cycle.
- R5: Code 3 (negate/absolute value) claims unpack, then shift. Such requests issue on every cycle.
- R6: Code 4 (compare) claims unpack, add, then round. Such requests issue on every cycle.
- R7: Code 2 (divide) claims unpack, add, round, 27 cycles of divide, then divide+add, divide+round, divide+add, divide+round, add, and round (36 steps). When a divide request is held after a divide has issued, it stalls for 31 cycles and issues on the 32nd.
- R8: After a multiply issues on an otherwise empty window, an add requested 1, 2 or 3 cycles later issues, one requested 4 or 5 cycles later stalls, and one requested 6 or more cycles later issues.
- R9: Codes 5, 6 and 7 are not supported. A valid request with one of them always stalls and leaves the window unchanged.
- R10: When no valid request is presented, neither issue nor stall is raised. A stalled request leaves the window unchanged, so the window keeps shifting as if nothing were requested.
- R11: A request whose pattern is longer than the window depth parameter stalls. A pattern exactly as long as the window may issue.
- R12: A synchronous active-high reset clears the whole window and both flags within one clock, and this overrides any request.
- R13: `issue_o` and `stall_o` are registered and refer to the request sampled at the previous clock edge. They are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid_i | input | 1 | A request is presented this cycle |
| req_op_i | input | 3 | Operation code of the request |
| issue_o | output | 1 | Request of the previous cycle was issued |
| stall_o | output | 1 | Request of the previous cycle was refused |
| stage_busy_o | output | 8 | Stage resources claimed for the current cycle |

## Verification
Several properties are checked on every cycle: the flags are exclusive, each flag follows a valid request, unsupported codes never issue, and unpack is busy exactly in the cycle after an issue. The checks also cover the second step each operation type claims and the clearing done by reset. Other behaviour depends on the whole window and can only be shown by the bench's scenarios. This includes the exact issue cadence of repeated adds, multiplies, compares and divides, and the add-after-multiply stall offsets. It also includes the window staying unchanged across stalls and the refusal of a pattern that is longer than a shallow window.

// File: rtl/fp_rsv_pkg.sv
package fp_rsv_pkg;

  localparam int NRES = 8;

  typedef logic [NRES-1:0] res_vec_t;

  // resource bits
  localparam res_vec_t RES_U = 8'h01;
  localparam res_vec_t RES_S = 8'h02;
  localparam res_vec_t RES_A = 8'h04;
  localparam res_vec_t RES_R = 8'h08;
  localparam res_vec_t RES_D = 8'h10;
  localparam res_vec_t RES_E = 8'h20;
  localparam res_vec_t RES_M = 8'h40;
  localparam res_vec_t RES_N = 8'h80;

  typedef enum logic [2:0] {
    FOP_ADD = 3'd0,
    FOP_MUL = 3'd1,
    FOP_DIV = 3'd2,
    FOP_NEG = 3'd3,
    FOP_CMP = 3'd4
  } fp_op_e;

  localparam int DIV_RUN  = 27;               // plain divide cycles
  localparam int DIV_TAIL = 3 + DIV_RUN;      // first mixed divide step
  localparam int DIV_LEN  = DIV_TAIL + 6;

  // number of steps an operation occupies; 0 means unsupported
  function automatic int op_len(logic [2:0] op);
    case (op)
      FOP_ADD: return 4;
      FOP_MUL: return 8;
      FOP_DIV: return DIV_LEN;
      FOP_NEG: return 2;
      FOP_CMP: return 3;
      default: return 0;
    endcase
  endfunction

  // resources claimed by an operation k cycles after it starts
  function automatic res_vec_t op_step(logic [2:0] op, int k);
    res_vec_t r;
    r = '0;
    case (op)
      FOP_ADD: begin
        case (k)
          0: r = RES_U;
          1: r = RES_S | RES_A;
          2: r = RES_A | RES_R;
          3: r = RES_R | RES_S;
          default: r = '0;
        endcase
      end
      FOP_MUL: begin
        case (k)
          0: r = RES_U;
          1: r = RES_E | RES_M;
          2, 3, 4: r = RES_M;
          5: r = RES_N;
          6: r = RES_N | RES_A;
          7: r = RES_R;
          default: r = '0;
        endcase
      end
      FOP_DIV: begin
        if (k == 0) r = RES_U;
        else if (k == 1) r = RES_A;
        else if (k == 2) r = RES_R;
        else if (k >= 3 && k < DIV_TAIL) r = RES_D;
        else if (k >= DIV_TAIL && k < DIV_TAIL + 4)
          r = RES_D | ((((k - DIV_TAIL) % 2) == 0) ? RES_A : RES_R);
        else if (k == DIV_TAIL + 4) r = RES_A;
        else if (k == DIV_TAIL + 5) r = RES_R;
        else r = '0;
      end
      FOP_NEG: begin
        case (k)
          0: r = RES_U;
          1: r = RES_S;
          default: r = '0;
        endcase
      end
      FOP_CMP: begin
        case (k)
          0: r = RES_U;
          1: r = RES_A;
          2: r = RES_R;
          default: r = '0;
        endcase
      end
      default: r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/fp_op_pattern.sv
module fp_op_pattern
  import fp_rsv_pkg::*;
#(
  parameter int DEPTH = 40
) (
  input  logic [2:0]                       op_i,
  output logic [DEPTH-1:0][NRES-1:0]       pat_o,
  output logic                             known_o,
  output logic                             fits_o
);

  for (genvar k = 0; k < DEPTH; k++) begin : g_step
    assign pat_o[k] = op_step(op_i, k);
  end

  assign known_o = (op_len(op_i) != 0);
  assign fits_o  = (op_len(op_i) <= DEPTH);

endmodule

// File: rtl/fp_rsv_table.sv
module fp_rsv_table
  import fp_rsv_pkg::*;
#(
  parameter int DEPTH = 40
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             merge_i,
  input  logic [DEPTH-1:0][NRES-1:0]       pat_i,
  output logic [DEPTH-1:0][NRES-1:0]       tbl_o
);

  localparam int TBL_W = DEPTH * NRES;

  logic [DEPTH-1:0][NRES-1:0] advanced;
  logic [DEPTH-1:0][NRES-1:0] claim;

  // entry k takes entry k+1; the far end fills with free cycles
  assign advanced = TBL_W'(tbl_o >> NRES);
  assign claim    = merge_i ? pat_i : '0;

  always_ff @(posedge clk) begin
    if (rst) tbl_o <= '0;
    else     tbl_o <= advanced | claim;
  end

endmodule

// File: rtl/fp_conflict_detect.sv
module fp_conflict_detect
  import fp_rsv_pkg::*;
#(
  parameter int DEPTH = 40
) (
  input  logic [DEPTH-1:0][NRES-1:0]       tbl_i,
  input  logic [DEPTH-1:0][NRES-1:0]       pat_i,
  output logic                             clash_o
);

  localparam int TBL_W = DEPTH * NRES;

  logic [DEPTH-1:0][NRES-1:0] ahead;
  logic [DEPTH-1:0]           hit;

  // a step starting after this edge lands on entry k+1 of today's window
  assign ahead = TBL_W'(tbl_i >> NRES);

  for (genvar k = 0; k < DEPTH; k++) begin : g_cmp
    assign hit[k] = |(pat_i[k] & ahead[k]);
  end

  assign clash_o = |hit;

endmodule

// File: rtl/fp_issue_gate.sv
module fp_issue_gate
  import fp_rsv_pkg::*;
#(
  parameter int DEPTH = 40
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid_i,
  input  logic [2:0]            req_op_i,
  output logic                  issue_o,
  output logic                  stall_o,
  output logic [NRES-1:0]       stage_busy_o
);

  logic [DEPTH-1:0][NRES-1:0] pat;
  logic [DEPTH-1:0][NRES-1:0] tbl;
  logic                       known;
  logic                       fits;
  logic                       clash;
  logic                       grant;

  fp_op_pattern #(.DEPTH(DEPTH)) i_pattern (
    .op_i    (req_op_i),
    .pat_o   (pat),
    .known_o (known),
    .fits_o  (fits)
  );

  fp_conflict_detect #(.DEPTH(DEPTH)) i_detect (
    .tbl_i   (tbl),
    .pat_i   (pat),
    .clash_o (clash)
  );

  assign grant = req_valid_i && known && fits && !clash;

  fp_rsv_table #(.DEPTH(DEPTH)) i_table (
    .clk     (clk),
    .rst     (rst),
    .merge_i (grant),
    .pat_i   (pat),
    .tbl_o   (tbl)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      issue_o <= 1'b0;
      stall_o <= 1'b0;
    end else begin
      issue_o <= grant;
      stall_o <= req_valid_i && !grant;
    end
  end

  assign stage_busy_o = tbl[0];

endmodule

// File: rtl/fp_issue_gate_chk.sv
module fp_issue_gate_chk (
  input logic       clk,
  input logic       rst,
  input logic       req_valid_i,
  input logic [2:0] req_op_i,
  input logic       issue_o,
  input logic       stall_o,
  input logic [7:0] stage_busy_o
);

  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  always @(negedge clk) begin
    if (rst_q === 1'b1)
      AST_RESET_CLEARS: assert (!issue_o && !stall_o && stage_busy_o == 8'h00); // R12
  end

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(issue_o && stall_o)); // R13

  AST_ISSUE_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
    issue_o |-> $past(req_valid_i)); // R10

  AST_STALL_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
    stall_o |-> $past(req_valid_i)); // R10

  AST_BAD_CODE_NEVER_ISSUES: assert property (@(posedge clk) disable iff (rst)
    issue_o |-> ($past(req_op_i) <= 3'd4)); // R9

  AST_UNPACK_ON_ISSUE: assert property (@(posedge clk) disable iff (rst)
    issue_o |-> stage_busy_o[0]); // R1

  AST_UNPACK_ONLY_ON_ISSUE: assert property (@(posedge clk) disable iff (rst)
    stage_busy_o[0] |-> issue_o); // R2

  AST_ADD_SECOND_STEP: assert property (@(posedge clk) disable iff (rst)
    (issue_o && $past(req_op_i) == 3'd0) |=> (stage_busy_o[1] && stage_busy_o[2])); // R3

  AST_MUL_SECOND_STEP: assert property (@(posedge clk) disable iff (rst)
    (issue_o && $past(req_op_i) == 3'd1) |=> (stage_busy_o[5] && stage_busy_o[6])); // R4

  AST_NEG_SECOND_STEP: assert property (@(posedge clk) disable iff (rst)
    (issue_o && $past(req_op_i) == 3'd3) |=> stage_busy_o[1]); // R5

  AST_CMP_SECOND_STEP: assert property (@(posedge clk) disable iff (rst)
    (issue_o && $past(req_op_i) == 3'd4) |=> stage_busy_o[2]); // R6

  AST_DIV_SECOND_STEP: assert property (@(posedge clk) disable iff (rst)
    (issue_o && $past(req_op_i) == 3'd2) |=> stage_busy_o[2]); // R7

endmodule

bind fp_issue_gate fp_issue_gate_chk i_chk (
  .clk          (clk),
  .rst          (rst),
  .req_valid_i  (req_valid_i),
  .req_op_i     (req_op_i),
  .issue_o      (issue_o),
  .stall_o      (stall_o),
  .stage_busy_o (stage_busy_o)
);

// File: tb/test_fp_issue_gate.sv
module test_fp_issue_gate;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic [2:0] req_op = 3'd0;
  logic       issue;
  logic       stall;
  logic [7:0] busy;

  logic       s_valid = 1'b0;
  logic [2:0] s_op = 3'd0;
  logic       s_issue;
  logic       s_stall;
  logic [7:0] s_busy;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  fp_issue_gate #(.DEPTH(40)) i_fp_issue_gate (
    .clk (clk), .rst (rst), .req_valid_i (req_valid), .req_op_i (req_op),
    .issue_o (issue), .stall_o (stall), .stage_busy_o (busy)
  );

  fp_issue_gate #(.DEPTH(8)) i_small (
    .clk (clk), .rst (rst), .req_valid_i (s_valid), .req_op_i (s_op),
    .issue_o (s_issue), .stall_o (s_stall), .stage_busy_o (s_busy)
  );

  // vector: {tag[3:0], valid, op[2:0], expected issue}
  localparam logic [8:0] IDL = {4'd10, 1'b0, 3'd0, 1'b0};
  localparam int NV = 61;
  localparam logic [8:0] VEC [NV] = '{
    {4'd3,1'b1,3'd0,1'b1}, {4'd3,1'b1,3'd0,1'b0}, {4'd3,1'b1,3'd0,1'b0}, {4'd3,1'b1,3'd0,1'b1},
    IDL, IDL, IDL, IDL,
    {4'd8,1'b1,3'd1,1'b1}, IDL, IDL, IDL,
    {4'd8,1'b1,3'd0,1'b0}, {4'd8,1'b1,3'd0,1'b0}, {4'd8,1'b1,3'd0,1'b1},
    IDL, IDL, IDL, IDL, IDL,
    {4'd8,1'b1,3'd1,1'b1}, IDL, IDL, {4'd8,1'b1,3'd0,1'b1},
    IDL, IDL, IDL, IDL, IDL,
    {4'd4,1'b1,3'd1,1'b1}, {4'd4,1'b1,3'd1,1'b0}, {4'd4,1'b1,3'd1,1'b0}, {4'd4,1'b1,3'd1,1'b0},
    {4'd4,1'b1,3'd1,1'b1},
    IDL, IDL, IDL, IDL, IDL, IDL, IDL, IDL,
    {4'd5,1'b1,3'd3,1'b1}, {4'd5,1'b1,3'd3,1'b1}, {4'd5,1'b1,3'd3,1'b1}, IDL, IDL,
    {4'd6,1'b1,3'd4,1'b1}, {4'd6,1'b1,3'd4,1'b1}, IDL, IDL, IDL,
    {4'd9,1'b1,3'd5,1'b0}, {4'd9,1'b1,3'd6,1'b0}, {4'd9,1'b1,3'd7,1'b0},
    {4'd2,1'b1,3'd0,1'b1}, {4'd2,1'b1,3'd3,1'b1}, IDL, IDL, IDL, IDL
  };

  function automatic string tg(logic [3:0] n);
    case (n)
      4'd2:    return "R2";
      4'd3:    return "R3";
      4'd4:    return "R4";
      4'd5:    return "R5";
      4'd6:    return "R6";
      4'd8:    return "R8";
      4'd9:    return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step(logic v, logic [2:0] op);
    req_valid = v;
    req_op    = op;
    @(negedge clk);
  endtask

  task automatic sstep(logic v, logic [2:0] op);
    s_valid = v;
    s_op    = op;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R13 watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    int stalls;
    @(negedge clk);
    // R12: reset overrides a request
    step(1'b1, 3'd1);
    step(1'b1, 3'd1);
    chk("R12", "issue in reset", issue, 0);
    chk("R12", "stall in reset", stall, 0);
    chk("R12", "busy in reset", busy, 8'h00);
    rst = 1'b0;
    step(1'b0, 3'd0);

    // table-driven scenarios
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][4], VEC[i][3:1]);
      chk(tg(VEC[i][8:5]), $sformatf("issue vec %0d", i), issue, VEC[i][0]);
      chk(tg(VEC[i][8:5]), $sformatf("stall vec %0d", i), stall, VEC[i][4] & ~VEC[i][0]);
    end

    // R1 R3: add step sequence
    step(1'b1, 3'd0); chk("R1", "add step0", busy, 8'h01);
    step(1'b0, 3'd0); chk("R3", "add step1", busy, 8'h06);
    step(1'b0, 3'd0); chk("R3", "add step2", busy, 8'h0C);
    step(1'b0, 3'd0); chk("R3", "add step3", busy, 8'h0A);
    step(1'b0, 3'd0); chk("R3", "add done", busy, 8'h00);

    // R4 R10: multiply sequence, stalled adds leave it intact
    step(1'b1, 3'd1); chk("R4", "mul step0", busy, 8'h01);
    step(1'b0, 3'd0); chk("R4", "mul step1", busy, 8'h60);
    step(1'b0, 3'd0); chk("R4", "mul step2", busy, 8'h40);
    step(1'b0, 3'd0); chk("R4", "mul step3", busy, 8'h40);
    step(1'b1, 3'd0); chk("R10", "stall keeps step4", busy, 8'h40);
    chk("R8", "add at 4 stalls", stall, 1);
    step(1'b1, 3'd0); chk("R10", "stall keeps step5", busy, 8'h80);
    step(1'b1, 3'd0); chk("R8", "add at 6 issues", issue, 1);
    chk("R2", "merged step", busy, 8'h85);
    step(1'b0, 3'd0); chk("R10", "no request no flags", issue + stall, 0);
    repeat (8) step(1'b0, 3'd0);

    // R9: unsupported code leaves empty window empty
    step(1'b1, 3'd7); chk("R9", "code 7 stall", stall, 1);
    chk("R9", "code 7 busy", busy, 8'h00);
    step(1'b1, 3'd5); chk("R9", "code 5 busy", busy, 8'h00);
    step(1'b0, 3'd0); chk("R9", "window after bad codes", busy, 8'h00);

    // R7: held divide waits 31 cycles
    step(1'b1, 3'd2); chk("R7", "first divide issues", issue, 1);
    stalls = 0;
    for (int d = 1; d <= 40; d++) begin
      step(1'b1, 3'd2);
      if (issue) break;
      stalls++;
    end
    chk("R7", "divide stall count", stalls, 31);
    chk("R7", "second divide issue", issue, 1);
    chk("R7", "busy at second issue", busy, 8'h15);

    // R12: reset mid-divide empties the window
    rst = 1'b1;
    step(1'b0, 3'd0);
    chk("R12", "busy after reset", busy, 8'h00);
    rst = 1'b0;
    step(1'b1, 3'd2); chk("R12", "divide issues after reset", issue, 1);
    step(1'b0, 3'd0);

    // R11: shallow window
    sstep(1'b1, 3'd1); chk("R11", "mul fits 8 deep", s_issue, 1);
    chk("R11", "small busy", s_busy, 8'h01);
    repeat (8) sstep(1'b0, 3'd0);
    sstep(1'b1, 3'd2); chk("R11", "divide too long stalls", s_stall, 1);
    chk("R11", "divide leaves window", s_busy, 8'h00);
    sstep(1'b1, 3'd0); chk("R11", "add issues small", s_issue, 1);
    sstep(1'b0, 3'd0);
    chk("R13", "flags exclusive", issue & stall, 0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule